// File: doc/BRIEF.md
# Add and Reverse-Subtract Integer Unit

This combinational unit produces the result of the add, reverse-subtract and compare operations of a 32-bit integer datapath. It receives operand A, a register value and an already sign-extended immediate for operand B, the current carry flag, and a 4-bit operation code. It returns the result word, the new carry value and a strobe that tells the surrounding flag register whether to load that value.

The four code bits act independently. Bit 0 inverts A and turns the operation into B minus A. Bit 1 replaces the implicit carry-in (0 for add, 1 for subtract) with the carry flag. Bit 2 holds the carry flag. Bit 3 takes B from the immediate instead of the register. A separate compare request, valid only with the register-form keep-carry subtract code, patches the top result bit so that it gives the signed or unsigned ordering of A against B.

Top module: `addsub_alu`

## Requirements
- R1: With code bits 0 and 1 clear, result equals A + B modulo 2^32; with bit 0 clear and bit 1 set, result equals A + B + carry_in.
- R2: With bit 0 set and bit 1 clear, result equals B + ~A + 1, that is B minus A modulo 2^32 (not A minus B).
- R3: With bits 0 and 1 both set, result equals B + ~A + carry_in (B minus A when carry_in is 1, one less when it is 0).
- R4: With code bit 2 clear, carry_we is 1 and carry_out is bit 32 of the 33-bit sum of the two (possibly inverted) operands and the carry-in; for plain reverse subtract this is 1 exactly when B >= A unsigned.
- R5: With code bit 2 set, carry_we is 0 and carry_out equals carry_in.
- R6: Code bit 3 set takes B from b_imm, clear takes it from b_reg; the unselected input has no effect on any output.
- R7: With cmp_en=1, cmp_uns=0 and code 0x5, bits 30..0 of result equal those of B minus A and bit 31 is 1 exactly when A > B as signed numbers; carry_we is 0.
- R8: With cmp_en=1, cmp_uns=1 and code 0x5, bits 30..0 are those of B minus A and bit 31 is 1 exactly when A > B as unsigned numbers; carry_we is 0.
- R9: For any code other than 0x5, cmp_en and cmp_uns have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Operand A |
| b_reg | input | 32 | Operand B, register form |
| b_imm | input | 32 | Operand B, sign-extended immediate form |
| op_code | input | 4 | bit0 reverse, bit1 carry-in, bit2 keep carry, bit3 immediate |
| carry_in | input | 1 | Current carry flag |
| cmp_en | input | 1 | Compare request, honoured only with code 0x5 |
| cmp_uns | input | 1 | 1 for unsigned compare, 0 for signed |
| result | output | 32 | Result word |
| carry_out | output | 1 | New carry flag value |
| carry_we | output | 1 | Carry flag load strobe |

## Verification
The checks inside the unit assume the inputs are settled when evaluated, with no unknown bits on operands or code, since every property compares the result against a second arithmetic form of the same operands. The stimulus changes all inputs together on the falling clock edge and samples a few nanoseconds later, driving only fully defined values, including the corner operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF across every code and both compare flavours.

// File: rtl/addsub_alu.sv
module addsub_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_reg,
  input  logic [WIDTH-1:0] b_imm,
  input  logic [3:0]       op_code,
  input  logic             carry_in,
  input  logic             cmp_en,
  input  logic             cmp_uns,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             carry_we
);
  localparam int MSB = WIDTH - 1;
  localparam logic [3:0] CMP_CODE = 4'h5;

  logic rev, use_c, keep, use_imm;
  logic [WIDTH-1:0] opb, opx;
  logic cin, is_cmp, sign_split;
  logic [WIDTH:0] sum;

  assign rev     = op_code[0];
  assign use_c   = op_code[1];
  assign keep    = op_code[2];
  assign use_imm = op_code[3];

  assign opb = use_imm ? b_imm : b_reg;
  assign opx = rev ? ~a_in : a_in;
  assign cin = use_c ? carry_in : rev;
  assign sum = {1'b0, opx} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

  assign is_cmp     = cmp_en && (op_code == CMP_CODE);
  assign sign_split = a_in[MSB] ^ opb[MSB];

  assign result    = (is_cmp && sign_split) ?
                     {(cmp_uns ? a_in[MSB] : opb[MSB]), sum[MSB-1:0]} : sum[MSB:0];
  assign carry_we  = ~keep;
  assign carry_out = keep ? carry_in : sum[WIDTH];

  logic [WIDTH-1:0] chk_diff;

  always_comb begin
    chk_diff = opb - a_in;
    // R1
    add_value_chk: assert (rev || use_c || result == a_in + opb);
    // R2
    rsub_value_chk: assert (!rev || use_c || is_cmp || result == chk_diff);
    // R4
    rsub_carry_chk: assert (!rev || use_c || keep || carry_out == (opb >= a_in));
    // R5
    keep_hold_chk: assert (!keep || (!carry_we && carry_out == carry_in));
    // R7
    cmp_low_chk: assert (!is_cmp || result[MSB-1:0] == chk_diff[MSB-1:0]);
    // R8
    cmp_order_chk: assert (!is_cmp || !cmp_uns || result[MSB] == (a_in > opb));
  end
endmodule

// File: tb/addsub_alu_test.sv
module addsub_alu_test;
  logic clk = 0;
  always #10 clk = ~clk;

  logic [31:0] a_in, b_reg, b_imm, result;
  logic [3:0]  op_code;
  logic        carry_in, cmp_en, cmp_uns, carry_out, carry_we;
  int checks = 0, fails = 0;

  addsub_alu uut (.a_in(a_in), .b_reg(b_reg), .b_imm(b_imm), .op_code(op_code),
    .carry_in(carry_in), .cmp_en(cmp_en), .cmp_uns(cmp_uns),
    .result(result), .carry_out(carry_out), .carry_we(carry_we));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] br, input logic [31:0] bi,
                       input logic [3:0] op, input logic c, input logic ce, input logic cu);
    @(negedge clk);
    a_in = a; b_reg = br; b_imm = bi; op_code = op; carry_in = c; cmp_en = ce; cmp_uns = cu;
    #3;
  endtask

  task automatic model(input logic [31:0] a, input logic [31:0] br, input logic [31:0] bi,
                       input logic [3:0] op, input logic c, input logic ce, input logic cu,
                       output logic [31:0] r, output logic co, output logic we);
    logic [31:0] b;
    logic [32:0] w;
    b = op[3] ? bi : br;
    if (!op[0]) begin
      w = {1'b0, a} + {1'b0, b} + (op[1] ? {32'd0, c} : 33'd0);
      r = w[31:0]; co = w[32];
    end else if (!op[1]) begin
      r = b - a; co = (b >= a);
    end else begin
      r = b - a - {31'd0, !c}; co = c ? (b >= a) : (b > a);
    end
    if (ce && op == 4'h5)
      r[31] = cu ? (a > b) : ($signed(a) > $signed(b));
    we = !op[2];
    if (op[2]) co = c;
  endtask

  task automatic run_model(input string req, input logic [31:0] a, input logic [31:0] br,
                           input logic [31:0] bi, input logic [3:0] op, input logic c,
                           input logic ce, input logic cu);
    logic [31:0] r; logic co, we;
    apply(a, br, bi, op, c, ce, cu);
    model(a, br, bi, op, c, ce, cu, r, co, we);
    check(req, result, r);
    check(req, {31'd0, carry_out}, {31'd0, co});
    check(req, {31'd0, carry_we}, {31'd0, we});
  endtask

  task automatic t_idle;
    apply(0, 0, 0, 4'h0, 0, 0, 0);
    check("R1 idle result", result, 0);
    check("R4 idle carry_we", {31'd0, carry_we}, 1);
    check("R4 idle carry_out", {31'd0, carry_out}, 0);
  endtask

  task automatic t_add;
    apply(32'hFFFF_FFFF, 32'd1, 0, 4'h0, 0, 0, 0);
    check("R1 add wrap", result, 0);
    check("R4 add carry", {31'd0, carry_out}, 1);
    apply(32'd5, 32'd7, 0, 4'h2, 1, 0, 0);
    check("R1 addc", result, 13);
  endtask

  task automatic t_rsub;
    apply(32'd3, 32'd10, 0, 4'h1, 0, 0, 0);
    check("R2 rsub", result, 7);
    check("R4 rsub b>=a carry", {31'd0, carry_out}, 1);
    apply(32'd10, 32'd3, 0, 4'h1, 1, 0, 0);
    check("R2 rsub neg", result, 32'hFFFF_FFF9);
    check("R4 rsub b<a carry", {31'd0, carry_out}, 0);
  endtask

  task automatic t_carry_in;
    apply(32'd3, 32'd10, 0, 4'h3, 0, 0, 0);
    check("R3 rsubc c=0", result, 6);
    apply(32'd3, 32'd10, 0, 4'h3, 1, 0, 0);
    check("R3 rsubc c=1", result, 7);
    apply(32'd4, 32'd4, 0, 4'h3, 0, 0, 0);
    check("R3 rsubc equal c=0 carry", {31'd0, carry_out}, 0);
  endtask

  task automatic t_keep;
    apply(32'hFFFF_FFFF, 32'd1, 0, 4'h4, 0, 0, 0);
    check("R5 keep add we", {31'd0, carry_we}, 0);
    check("R5 keep add hold0", {31'd0, carry_out}, 0);
    apply(32'd9, 32'd1, 0, 4'h5, 1, 0, 0);
    check("R5 keep rsub hold1", {31'd0, carry_out}, 1);
    check("R2 keep rsub value", result, 32'hFFFF_FFF8);
  endtask

  task automatic t_imm_sel;
    apply(32'd1, 32'd100, 32'd20, 4'h8, 0, 0, 0);
    check("R6 imm used", result, 21);
    apply(32'd1, 32'd555, 32'd20, 4'h8, 0, 0, 0);
    check("R6 reg ignored", result, 21);
    apply(32'd1, 32'd100, 32'd777, 4'h0, 0, 0, 0);
    check("R6 imm ignored", result, 101);
  endtask

  task automatic t_cmp;
    apply(32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h5, 0, 1, 0);
    check("R7 signed 1>-1 msb", {31'd0, result[31]}, 1);
    check("R7 signed low bits", {1'b0, result[30:0]}, 32'h7FFF_FFFE);
    check("R7 no carry write", {31'd0, carry_we}, 0);
    apply(32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h5, 0, 1, 1);
    check("R8 unsigned 1<max msb", {31'd0, result[31]}, 0);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 0, 4'h5, 0, 1, 1);
    check("R8 unsigned msb", {31'd0, result[31]}, 1);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 0, 4'h5, 0, 1, 0);
    check("R7 signed min<max msb", {31'd0, result[31]}, 0);
  endtask

  task automatic t_cmp_ignored;
    apply(32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hD, 0, 1, 1);
    check("R9 imm code ignores cmp", result, 32'hFFFF_FFFE);
    apply(32'h0000_0001, 32'hFFFF_FFFF, 0, 4'h1, 0, 1, 0);
    check("R9 rsub ignores cmp", result, 32'hFFFF_FFFE);
  endtask

  task automatic t_sweep;
    logic [31:0] corner [4];
    corner[0] = 0; corner[1] = 32'h7FFF_FFFF; corner[2] = 32'h8000_0000; corner[3] = 32'hFFFF_FFFF;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run_model("R1-sweep corner", corner[i], corner[j], corner[3-j], op[3:0],
                    1'(i ^ j), 1'(op == 5), 1'(j[0]));
    for (int k = 0; k < 400; k++)
      run_model("R3 R7 R8 random", $urandom, $urandom, $urandom, 4'($urandom),
                1'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    a_in = 0; b_reg = 0; b_imm = 0; op_code = 0; carry_in = 0; cmp_en = 0; cmp_uns = 0;
    repeat (2) @(posedge clk);
    t_idle;
    t_add;
    t_rsub;
    t_carry_in;
    t_keep;
    t_imm_sel;
    t_cmp;
    t_cmp_ignored;
    t_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule